// File: doc/BRIEF.md
# Gated-Arming UART Receive Channel

This block receives one serial character at a time from an asynchronous line. It uses 8 data bits, no parity and one stop bit, with the least significant bit first. An external tick strobe runs at sixteen times the bit rate and paces the sampling. The line first passes through a two-flop synchronizer. A start bit is confirmed only if the line is still low at the middle of the bit. Each data bit and the stop bit are then sampled at their own mid-points. A finished character goes into a holding register and raises a ready flag. The host reads the register and pulses a read strobe, and this lowers the flag.

A framing flag and an overrun flag sit beside the ready flag, so software can judge a character before it uses it. A dedicated strobe clears both flags. The receive enable gates everything. While the enable is low, the receiver sits in a disarmed state. Start detection is only armed after the enabled receiver has seen the line high. A line that is already low when reception is enabled therefore never counts as a start bit. A stop bit that is sampled low also disarms the receiver until the line returns to mark.

The controller has five named states: DISARM, IDLE, START, DATA and STOP.
- DISARM→IDLE: enabled and the synchronized line is high.
- IDLE→START: the line is low.
- START→DATA: the line is low on the 8th tick.
- START→IDLE: the line is high on the 8th tick (a false start).
- DATA→STOP: on the 16th tick of the last data bit.
- STOP→IDLE: on the 16th tick, with the line high.
- STOP→DISARM: on the 16th tick, with the line low.
- Any state→DISARM: the enable is low.

Top module: `uart_rx_gated`

## Requirements
- R1: While `rx_en` is 0, no character is received and `data_ready` never rises.
- R2: A character is sent as a low start bit, then 8 data bits LSB first, then a high stop bit. One clock after the tick at mid-stop, it appears on `rx_data` with `data_ready` = 1 and `frame_err` = 0.
- R3: A start bit counts only if the synchronized line is still low on the 8th tick after the falling edge. A shorter low pulse is dropped and the receiver stays armed.
- R4: After reset or an enable, the receiver recognizes no start bit until the enabled receiver has seen the synchronized line high.
- R5: A pulse on `rd_strobe` clears `data_ready` to 0 on the next clock.
- R6: If a stop bit is sampled low, `frame_err` is set and the character is still loaded with `data_ready` = 1. The receiver then disarms until the line returns high.
- R7: If a character completes while `data_ready` is 1, `overrun` is set. `rx_data` keeps the unread character.
- R8: `err_clr` clears `frame_err` and `overrun`. A new error in the same cycle wins over the clear.
- R9: Dropping `rx_en` during a character abandons that character and returns the receiver to DISARM.
- R10: After reset, `rx_data` = 0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Host has read `rx_data`; clears ready |
| err_clr | input | 1 | Clears framing and overrun flags |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Unread character present |
| frame_err | output | 1 | A stop bit was sampled low |
| overrun | output | 1 | A character arrived while one was unread |

## Verification
A character's flags and data become valid one clock after the tick at mid-stop. That tick falls about 610 clocks after the start edge at 64 clocks per bit. The bench checks every frame only after the whole stop bit has been driven, which leaves half a bit of margin. `rd_strobe` and `err_clr` act on the next clock, and the bench samples one negative edge after releasing each strobe. The negative cases (disabled, enabled while low, glitch, mid-frame abort and line held low after a framing error) wait at least a full character time before confirming that `data_ready` stayed low.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_DISARM = 3'd0,
        ST_IDLE   = 3'd1,
        ST_START  = 3'd2,
        ST_DATA   = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    output rx_state_e            state,
    output logic                 frame_done,
    output logic                 stop_ok,
    output logic [DATA_BITS-1:0] frame_data
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] BLST = BW'(DATA_BITS - 1);

    rx_state_e            st, nxt;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bit_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 at_mid, at_end;

    assign at_mid = tick && (cnt == MID);
    assign at_end = tick && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_DISARM;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        if (!en) begin
            nxt = ST_DISARM;
        end else begin
            unique case (st)
                ST_DISARM: if (line)  nxt = ST_IDLE;
                ST_IDLE:   if (!line) nxt = ST_START;
                ST_START:  if (at_mid) nxt = line ? ST_IDLE : ST_DATA;
                ST_DATA:   if (at_end && bit_cnt == BLST) nxt = ST_STOP;
                ST_STOP:   if (at_end) nxt = line ? ST_IDLE : ST_DISARM;
                default:   nxt = ST_DISARM;
            endcase
        end
    end

    // datapath: tick counter, bit counter, shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            if (nxt != st)  cnt <= '0;
            else if (tick)  cnt <= cnt + 1'b1;

            if (st != ST_DATA) begin
                bit_cnt <= '0;
            end else if (at_end) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {line, shreg[DATA_BITS-1:1]};
            end
        end
    end

    // outputs
    always_comb begin
        state      = st;
        frame_done = en && (st == ST_STOP) && at_end;
        stop_ok    = line;
        frame_data = shreg;
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic                 stop_ok,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 rd_strobe,
    input  logic                 err_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 frame_err,
    output logic                 overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (rd_strobe) data_ready <= 1'b0;
            if (err_clr) begin
                frame_err <= 1'b0;
                overrun   <= 1'b0;
            end
            if (frame_done) begin
                if (data_ready) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data    <= frame_data;
                    data_ready <= 1'b1;
                    if (!stop_ok) frame_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_gated.sv
module uart_rx_gated
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 tick16,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    input  logic                 err_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 frame_err,
    output logic                 overrun
);
    logic                 line_s;
    rx_state_e            st;
    logic                 frame_done;
    logic                 stop_ok;
    logic [DATA_BITS-1:0] frame_data;

    uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_rx_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .tick      (tick16),
        .line      (line_s),
        .state     (st),
        .frame_done(frame_done),
        .stop_ok   (stop_ok),
        .frame_data(frame_data)
    );

    uart_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .stop_ok   (stop_ok),
        .frame_data(frame_data),
        .rd_strobe (rd_strobe),
        .err_clr   (err_clr),
        .rx_data   (rx_data),
        .data_ready(data_ready),
        .frame_err (frame_err),
        .overrun   (overrun)
    );
endmodule

// File: rtl/uart_rx_gated_chk.sv
module uart_rx_gated_chk
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 rd_strobe,
    input logic                 err_clr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 data_ready,
    input logic                 frame_err,
    input logic                 overrun,
    input rx_state_e            st,
    input logic                 line_s,
    input logic                 frame_done,
    input logic                 stop_ok
);
    a_r1_no_ready_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !$rose(data_ready));

    a_r2_ready_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(frame_done));

    a_r4_stay_disarmed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISARM && !line_s) |=> st == ST_DISARM);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && data_ready) |=> !data_ready);

    a_r6_bad_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !stop_ok && !data_ready) |=> (frame_err && data_ready));

    a_r7_unread_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_strobe) |=> $stable(rx_data));

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && data_ready) |=> overrun);

    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !frame_done) |=> (!frame_err && !overrun));

    a_r9_disable_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> st == ST_DISARM);
endmodule

bind uart_rx_gated uart_rx_gated_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rd_strobe (rd_strobe),
    .err_clr   (err_clr),
    .rx_data   (rx_data),
    .data_ready(data_ready),
    .frame_err (frame_err),
    .overrun   (overrun),
    .st        (st),
    .line_s    (line_s),
    .frame_done(frame_done),
    .stop_ok   (stop_ok)
);

// File: tb/uart_rx_gated_tb.sv
module uart_rx_gated_tb;
    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, frame_err, overrun;

    int checks = 0;
    int errors = 0;
    int tdiv   = 0;

    always #5 clk = ~clk;

    uart_rx_gated u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
        .data_ready(data_ready), .frame_err(frame_err), .overrun(overrun)
    );

    always @(negedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_v);
        rxd = 1'b0; wait_clk(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; wait_clk(BITCLK);
        end
        rxd = stop_v; wait_clk(BITCLK);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; wait_clk(1); rd_strobe = 1'b0; wait_clk(1);
    endtask

    task automatic do_clr();
        err_clr = 1'b1; wait_clk(1); err_clr = 1'b0; wait_clk(1);
    endtask

    task automatic t_reset();
        chk(rx_data == 8'h00, "R10 data", rx_data, 0);
        chk({data_ready, frame_err, overrun} == 3'b000, "R10 flags",
            {data_ready, frame_err, overrun}, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 1'b1); wait_clk(4);
        chk(data_ready, "R2 ready", data_ready, 1);
        chk(rx_data == 8'hA5, "R2 data", rx_data, 8'hA5);
        chk(!frame_err, "R2 no frame_err", frame_err, 0);
        do_read();
        chk(!data_ready, "R5 read clears", data_ready, 0);
    endtask

    task automatic t_overrun();
        send(8'h3C, 1'b1); wait_clk(4);
        send(8'hFF, 1'b1); wait_clk(4);
        chk(overrun, "R7 overrun", overrun, 1);
        chk(rx_data == 8'h3C, "R7 data kept", rx_data, 8'h3C);
        do_read(); do_clr();
        chk(!overrun, "R8 overrun cleared", overrun, 0);
    endtask

    task automatic t_framing();
        send(8'h81, 1'b0); wait_clk(4);
        chk(frame_err, "R6 frame_err", frame_err, 1);
        chk(data_ready && rx_data == 8'h81, "R6 data loaded", rx_data, 8'h81);
        do_read();
        wait_clk(800);   // line stays low: must not start a new frame
        chk(!data_ready, "R6 disarmed while low", data_ready, 0);
        rxd = 1'b1; wait_clk(40); do_clr();
        chk(!frame_err, "R8 frame_err cleared", frame_err, 0);
        send(8'h55, 1'b1); wait_clk(4);
        chk(data_ready && rx_data == 8'h55, "R6 rearmed after mark", rx_data, 8'h55);
        do_read();
    endtask

    task automatic t_glitch();
        rxd = 1'b0; wait_clk(16); rxd = 1'b1; wait_clk(800);
        chk(!data_ready, "R3 glitch dropped", data_ready, 0);
        send(8'h6E, 1'b1); wait_clk(4);
        chk(data_ready && rx_data == 8'h6E, "R3 still armed", rx_data, 8'h6E);
        do_read();
    endtask

    task automatic t_disabled();
        rx_en = 1'b0; wait_clk(4);
        send(8'h12, 1'b1); wait_clk(100);
        chk(!data_ready, "R1 disabled", data_ready, 0);
    endtask

    task automatic t_enable_low();
        rxd = 1'b0; wait_clk(8); rx_en = 1'b1;
        wait_clk(200); rxd = 1'b1; wait_clk(1000);
        chk(!data_ready, "R4 low at enable ignored", data_ready, 0);
        send(8'h42, 1'b1); wait_clk(4);
        chk(data_ready && rx_data == 8'h42, "R4 armed after mark", rx_data, 8'h42);
        do_read();
    endtask

    task automatic t_abort();
        fork
            send(8'h00, 1'b1);
            begin wait_clk(300); rx_en = 1'b0; end
        join
        wait_clk(40); rx_en = 1'b1; wait_clk(700);
        chk(!data_ready, "R9 aborted frame", data_ready, 0);
        send(8'hC3, 1'b1); wait_clk(4);
        chk(data_ready && rx_data == 8'hC3, "R9 recovers", rx_data, 8'hC3);
        do_read();
    endtask

    initial begin
        wait_clk(5); rst_n = 1'b1; wait_clk(2);
        t_reset();
        rx_en = 1'b1; wait_clk(20);
        t_basic();
        t_overrun();
        t_framing();
        t_glitch();
        t_disabled();
        t_enable_low();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule